// File: doc/BRIEF.md
# SAR Conversion Sequencer

The sequencer runs the digital side of a successive-approximation converter. It waits for a start event from one selectable source. For each conversion it steps through an optional power-up wait, a tracking window and a bit-by-bit decision phase. It offers a trial code to an external comparator and reads the decision back one bit at a time. The phase timing comes from a SAR clock that is derived from the ADC clock by a programmable divider. The SAR clock exists only as a one-cycle tick enable.

A single start event can launch a burst of conversions. The burst length is a power of two. The samples are summed in an accumulator that cannot overflow, and the sum is shifted right by a selectable amount to average them. The configuration is captured when a start is accepted, so software may prepare the next setting while a burst is still running. A one-cycle done pulse marks the final result, and a busy flag covers the whole burst.

Top module: `sar_conv_seq`

## Requirements
- R1: One SAR period lasts `clk_div_i + 1` ADC clock cycles. It restarts at the first cycle of every tracking and conversion phase.
- R2: When `pwr_off_en_i` is 1, each conversion in a burst is preceded by a power-up phase of `4*(pwr_time_i+1)+2` cycles, with `track_o` and `bit_strobe_o` low. When `pwr_off_en_i` is 0, this phase is absent.
- R3: Tracking lasts `trk_time_i` SAR periods (a value of 0 counts as 1), and `track_o` is high for exactly those cycles.
- R4: The conversion phase lasts N+1 SAR periods. N is set by `res_sel_i`: 0 gives 10, 1 gives 12, 2 and 3 give 14. `bit_strobe_o` pulses in the last cycle of each of the first N periods.
- R5: The bits are decided from bit N-1 down to bit 0. During the period for bit k, `trial_o` equals the bits kept so far with bit k set. Bit k is kept when `cmp_i` is 1 at its strobe, meaning the input is at or above the trial level. A constant input V below 2^N therefore converts to V.
- R6: One accepted start runs the whole burst. The burst is 2^min(rpt_i,5) conversions when `rpt_ext_i` is 0, and 2^rpt_i conversions when it is 1.
- R7: `result_o` becomes the burst sum shifted right by `shift_i` in the done cycle. It holds that value until the next done.
- R8: `trig_src_i` selects the start: 0 is `sw_trig_i` high, 1 to 10 is `hw_trig_i[trig_src_i-1]` high, 11 is a rising edge of `ext_start_i` (high now, low in the previous cycle), and 12 to 15 is never.
- R9: A start seen while `busy_o` is high is ignored, and that includes the done cycle.
- R10: `busy_o` rises in the cycle after the accepted start and falls after the done cycle. `done_o` is high for exactly one cycle, at the end of the burst.
- R11: The accumulator is wide enough that a burst of 128 full-scale 14-bit samples does not wrap.
- R12: All configuration inputs are captured when a start is accepted. Changing them while busy has no effect on the running burst.
- R13: After reset, `busy_o`, `done_o`, `track_o`, `bit_strobe_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | 5 | SAR clock divider minus one |
| pwr_off_en_i | input | 1 | Power-up wait before each conversion |
| pwr_time_i | input | 5 | Power-up length field |
| trk_time_i | input | 6 | Tracking length in SAR periods |
| res_sel_i | input | 2 | Resolution select |
| rpt_i | input | 3 | Burst length exponent |
| rpt_ext_i | input | 1 | Allow bursts above 32 |
| shift_i | input | 3 | Right shift applied to the sum |
| trig_src_i | input | 4 | Start source select |
| sw_trig_i | input | 1 | Software start request |
| hw_trig_i | input | 10 | Hardware start lines |
| ext_start_i | input | 1 | External start pin, edge sensitive |
| cmp_i | input | 1 | Comparator decision, input at or above trial |
| track_o | output | 1 | Sampling switch enable |
| bit_strobe_o | output | 1 | Comparator latch strobe |
| trial_o | output | 14 | Trial code for the capacitor DAC |
| result_o | output | 21 | Shifted burst sum |
| done_o | output | 1 | Burst complete pulse |
| busy_o | output | 1 | Burst in progress |

## Verification
The assertions assume that `cmp_i` is a function of `trial_o` that settles within one cycle. They also assume that `ext_start_i` is already synchronous to the ADC clock. The bench derives `cmp_i` combinationally from a fixed input level compared against `trial_o`, and it drives every input on the falling edge. The input level is held constant during each burst, so the expected sum is simply the burst length times the converted value. The configuration is deliberately changed during a burst to check that the captured values are the ones in use.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_MAX = 14;
  localparam int RPT_NORM_MAX = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PWR,
    S_TRK,
    S_CNV,
    S_FIN
  } seq_state_e;

  function automatic logic [3:0] res_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd10;
      2'd1:    return 4'd12;
      default: return 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel #(
  parameter int SRC_W = 4,
  parameter int N_HW  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_i,
  input  logic             sw_i,
  input  logic [N_HW-1:0]  hw_i,
  input  logic             ext_i,
  output logic             hit_o
);
  localparam int SRC_EXT = N_HW + 1;

  logic ext_q;
  logic ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_i;
  end

  assign ext_rise = ext_i & ~ext_q;

  always_comb begin
    hit_o = 1'b0;
    if (src_i == '0)                          hit_o = sw_i;
    else if (int'(src_i) <= N_HW)             hit_o = hw_i[int'(src_i) - 1];
    else if (int'(src_i) == SRC_EXT)          hit_o = ext_rise;
  end

  // R8
  ext_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(src_i) == SRC_EXT && hit_o) |-> !ext_q);
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int RES_W = 14,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             active_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] value_o
);
  for (genvar b = 0; b < RES_W; b++) begin : g_bit
    logic sel;
    assign sel = (bit_idx_i == IDX_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           value_o[b] <= 1'b0;
      else if (clr_i)        value_o[b] <= 1'b0;
      else if (step_i && sel) value_o[b] <= cmp_i;
    end
    assign trial_o[b] = value_o[b] | (active_i & sel);
  end

  // R5
  step_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> active_i);

  // R5
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (value_o == '0));
endmodule

// File: rtl/sar_accum.sv
module sar_accum #(
  parameter int RES_W = 14,
  parameter int ACC_W = 21,
  parameter int SHF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic             last_i,
  input  logic [RES_W-1:0] sample_i,
  input  logic [SHF_W-1:0] shift_i,
  output logic [ACC_W-1:0] result_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w = {1'b0, acc_q} + (ACC_W + 1)'(sample_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      result_o <= '0;
    end else begin
      if (clr_i)      acc_q <= '0;
      else if (add_i) acc_q <= sum_w[ACC_W-1:0];
      if (add_i && last_i) result_o <= sum_w[ACC_W-1:0] >> shift_i;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> !sum_w[ACC_W]);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int PWR_W = 5,
  parameter int TRK_W = 6,
  parameter int RPT_W = 3,
  parameter int SHF_W = 3,
  parameter int SRC_W = 4,
  parameter int N_HW  = 10,
  localparam int ACC_W = RES_MAX + (1 << RPT_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic               pwr_off_en_i,
  input  logic [PWR_W-1:0]   pwr_time_i,
  input  logic [TRK_W-1:0]   trk_time_i,
  input  logic [1:0]         res_sel_i,
  input  logic [RPT_W-1:0]   rpt_i,
  input  logic               rpt_ext_i,
  input  logic [SHF_W-1:0]   shift_i,
  input  logic [SRC_W-1:0]   trig_src_i,
  input  logic               sw_trig_i,
  input  logic [N_HW-1:0]    hw_trig_i,
  input  logic               ext_start_i,
  input  logic               cmp_i,
  output logic               track_o,
  output logic               bit_strobe_o,
  output logic [RES_MAX-1:0] trial_o,
  output logic [ACC_W-1:0]   result_o,
  output logic               done_o,
  output logic               busy_o
);
  localparam int PCY_W = PWR_W + 3;
  localparam int PER_W = (TRK_W > 5) ? TRK_W : 5;
  localparam int CNT_W = (1 << RPT_W);
  localparam int IDX_W = 4;

  seq_state_e state_q, state_d;
  logic trig_hit;

  logic [DIV_W-1:0] div_q, dcnt_q;
  logic             pwr_en_q;
  logic [PWR_W-1:0] pwr_q;
  logic [TRK_W-1:0] trk_q;
  logic [3:0]       nbits_q;
  logic [SHF_W-1:0] shf_q;
  logic [CNT_W-1:0] total_q, conv_cnt_q;
  logic [PCY_W-1:0] cyc_q;
  logic [PER_W-1:0] per_q;

  logic             accept;
  logic             sar_tick, trk_end, bit_phase, strobe, cnv_end, last_conv;
  logic [PER_W-1:0] trk_last;
  logic [IDX_W-1:0] cur_bit;
  logic [PWR_W-1:0] pwr_sel;
  logic [PCY_W-1:0] pwr_load;
  logic [RPT_W-1:0] rpt_eff;
  logic [RES_MAX-1:0] sar_val;

  sar_trig_sel #(.SRC_W(SRC_W), .N_HW(N_HW)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (trig_src_i),
    .sw_i  (sw_trig_i),
    .hw_i  (hw_trig_i),
    .ext_i (ext_start_i),
    .hit_o (trig_hit)
  );

  assign accept    = (state_q == S_IDLE) && trig_hit;
  assign sar_tick  = (dcnt_q == div_q);
  assign trk_last  = (trk_q == '0) ? '0 : PER_W'(trk_q) - PER_W'(1);
  assign trk_end   = (state_q == S_TRK) && sar_tick && (per_q == trk_last);
  assign bit_phase = (state_q == S_CNV) && (per_q < PER_W'(nbits_q));
  assign strobe    = bit_phase && sar_tick;
  assign cnv_end   = (state_q == S_CNV) && sar_tick && (per_q == PER_W'(nbits_q));
  assign last_conv = (conv_cnt_q == total_q - CNT_W'(1));
  assign cur_bit   = nbits_q - 4'd1 - per_q[IDX_W-1:0];

  assign pwr_sel  = (state_q == S_IDLE) ? pwr_time_i : pwr_q;
  assign pwr_load = {pwr_sel, 2'b00} + PCY_W'(5);
  assign rpt_eff  = (rpt_ext_i || (int'(rpt_i) <= RPT_NORM_MAX)) ? rpt_i : RPT_W'(RPT_NORM_MAX);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (trig_hit) state_d = pwr_off_en_i ? S_PWR : S_TRK;
      S_PWR:  if (cyc_q == '0) state_d = S_TRK;
      S_TRK:  if (trk_end) state_d = S_CNV;
      S_CNV:  if (cnv_end) state_d = last_conv ? S_FIN : (pwr_en_q ? S_PWR : S_TRK);
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      div_q      <= '0;
      pwr_en_q   <= 1'b0;
      pwr_q      <= '0;
      trk_q      <= '0;
      nbits_q    <= 4'd14;
      shf_q      <= '0;
      total_q    <= CNT_W'(1);
      conv_cnt_q <= '0;
      cyc_q      <= '0;
      dcnt_q     <= '0;
      per_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        div_q      <= clk_div_i;
        pwr_en_q   <= pwr_off_en_i;
        pwr_q      <= pwr_time_i;
        trk_q      <= trk_time_i;
        nbits_q    <= res_bits(res_sel_i);
        shf_q      <= shift_i;
        total_q    <= CNT_W'(1) << rpt_eff;
        conv_cnt_q <= '0;
      end else if (cnv_end) begin
        conv_cnt_q <= conv_cnt_q + CNT_W'(1);
      end
      if (state_d == S_PWR && state_q != S_PWR) cyc_q <= pwr_load;
      else if (cyc_q != '0)                     cyc_q <= cyc_q - PCY_W'(1);
      if (state_d != state_q) begin
        dcnt_q <= '0;
        per_q  <= '0;
      end else if (sar_tick) begin
        dcnt_q <= '0;
        per_q  <= per_q + PER_W'(1);
      end else begin
        dcnt_q <= dcnt_q + DIV_W'(1);
      end
    end
  end

  sar_bit_reg #(.RES_W(RES_MAX), .IDX_W(IDX_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (trk_end),
    .active_i (bit_phase),
    .step_i   (strobe),
    .bit_idx_i(cur_bit),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .value_o  (sar_val)
  );

  sar_accum #(.RES_W(RES_MAX), .ACC_W(ACC_W), .SHF_W(SHF_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .add_i   (cnv_end),
    .last_i  (last_conv),
    .sample_i(sar_val),
    .shift_i (shf_q),
    .result_o(result_o)
  );

  assign track_o      = (state_q == S_TRK);
  assign bit_strobe_o = strobe;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_FIN);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R9
  trig_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(trig_hit));

  // R3
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track_o || bit_strobe_o) |-> (busy_o && !(track_o && bit_strobe_o)));

  // R2
  pwr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PWR) |-> (!track_o && !bit_strobe_o && pwr_en_q));
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  clk_div = '0;
  logic        pwr_en = 1'b0;
  logic [4:0]  pwr_t = '0;
  logic [5:0]  trk_t = 6'd1;
  logic [1:0]  res_sel = '0;
  logic [2:0]  rpt = '0;
  logic        rpt_ext = 1'b0;
  logic [2:0]  shf = '0;
  logic [3:0]  src = '0;
  logic        sw = 1'b0;
  logic [9:0]  hw = '0;
  logic        ext = 1'b0;
  int          vin = 0;
  logic        cmp;
  logic        track, strobe, done, busy;
  logic [13:0] trial;
  logic [20:0] result;

  assign cmp = (int'(trial) <= vin);

  sar_conv_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(clk_div), .pwr_off_en_i(pwr_en),
    .pwr_time_i(pwr_t), .trk_time_i(trk_t), .res_sel_i(res_sel), .rpt_i(rpt),
    .rpt_ext_i(rpt_ext), .shift_i(shf), .trig_src_i(src), .sw_trig_i(sw),
    .hw_trig_i(hw), .ext_start_i(ext), .cmp_i(cmp), .track_o(track),
    .bit_strobe_o(strobe), .trial_o(trial), .result_o(result), .done_o(done),
    .busy_o(busy)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural model: t counts cycles since acceptance, -1 when idle
  int t = -1;
  int mP, mT, mC, mL, mM, mD, mN;
  longint exp_run = 0;
  longint res_hold = 0;
  logic ext_prev = 1'b0;
  int bursts = 0;

  function automatic bit model_hit();
    if (src == 0) return sw;
    if (src <= 10) return hw[src - 1];
    if (src == 11) return ext && !ext_prev;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (t >= 0) begin
        if (t == mM * mL) t = -1;
        else t++;
      end else if (model_hit()) begin
        int r, v;
        mD = clk_div + 1;
        mP = pwr_en ? 4 * (pwr_t + 1) + 2 : 0;
        mT = ((trk_t == 0) ? 1 : trk_t) * mD;
        mN = (res_sel == 0) ? 10 : (res_sel == 1) ? 12 : 14;
        mC = (mN + 1) * mD;
        mL = mP + mT + mC;
        r = (rpt_ext || rpt <= 5) ? rpt : 5;
        mM = 1 << r;
        v = (vin > (1 << mN) - 1) ? (1 << mN) - 1 : vin;
        exp_run = (longint'(mM) * v) >> shf;
        t = 0;
        bursts++;
      end
      ext_prev = ext;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_busy, e_trk, e_stb, e_done;
      e_busy = (t >= 0);
      e_done = (t >= 0) && (t == mM * mL);
      e_trk = 1'b0;
      e_stb = 1'b0;
      if (t >= 0 && !e_done) begin
        int o, c;
        o = t % mL;
        e_trk = (o >= mP) && (o < mP + mT);
        c = o - mP - mT;
        e_stb = (c >= 0) && ((c % mD) == mD - 1) && (c / mD < mN);
      end
      if (e_done) res_hold = exp_run;
      chk("R10 busy", busy, e_busy);
      chk("R10 done", done, e_done);
      chk("R3 track", track, e_trk);
      chk("R4 strobe", strobe, e_stb);
      chk("R7 result", result, res_hold);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw();
    sw = 1'b1; step(1); sw = 1'b0;
  endtask

  task automatic wait_idle();
    step(1);
    while (t >= 0) step(1);
    step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R13 reset state
    chk("R13 busy", busy, 0);
    chk("R13 done", done, 0);
    chk("R13 result", result, 0);

    // R1 R3 R4 R5 R8: software start, 12 bits
    clk_div = 0; trk_t = 2; res_sel = 1; vin = 1234; src = 0;
    pulse_sw(); wait_idle();
    chk("R5 value", result, 1234);

    // R1 R2: divider 4, power-up wait, track 0 treated as 1, 10 bits full scale
    clk_div = 3; pwr_en = 1; pwr_t = 1; trk_t = 0; res_sel = 0; vin = 5000;
    pulse_sw(); wait_idle();
    chk("R5 clamp", result, 1023);

    // R4 R5: 14-bit extremes, res_sel 3
    pwr_en = 0; clk_div = 1; trk_t = 3; res_sel = 3; vin = 0;
    pulse_sw(); wait_idle();
    chk("R5 zero", result, 0);
    vin = 16383; res_sel = 2;
    pulse_sw(); wait_idle();
    chk("R5 full", result, 16383);

    // R6 R7: burst of 4, shift 1, with power-up per conversion
    clk_div = 0; pwr_en = 1; pwr_t = 0; trk_t = 1; res_sel = 1; rpt = 2; shf = 1; vin = 100;
    pulse_sw(); wait_idle();
    chk("R7 avg", result, 200);

    // R6: rpt 7 without extension caps at 32
    pwr_en = 0; rpt = 7; rpt_ext = 0; shf = 5; vin = 777;
    pulse_sw(); wait_idle();
    chk("R6 cap", result, 777);

    // R6 R11: 128 full-scale 14-bit samples
    res_sel = 2; rpt_ext = 1; shf = 0; vin = 16383;
    pulse_sw(); wait_idle();
    chk("R11 sum", result, 128 * 16383);

    // R8: hardware line 3 selected, other line ignored
    rpt = 0; rpt_ext = 0; res_sel = 0; vin = 321; src = 3;
    hw[1] = 1'b1; step(1); hw[1] = 1'b0; step(3);
    chk("R8 wrong line", busy, 0);
    hw[2] = 1'b1; step(1); hw[2] = 1'b0; wait_idle();
    chk("R8 hw", result, 321);
    // R8: software ignored under hw source
    sw = 1'b1; step(2); sw = 1'b0;
    chk("R8 sw masked", busy, 0);

    // R8: external edge, held high gives one burst only
    src = 11; vin = 55;
    begin
      int b0;
      b0 = bursts;
      ext = 1'b1; step(60); ext = 1'b0; wait_idle();
      chk("R8 one edge", bursts - b0, 1);
    end
    chk("R8 ext", result, 55);

    // R8: source 12 never starts
    src = 12; sw = 1'b1; hw = '1; ext = 1'b1; step(4);
    chk("R8 none", busy, 0);
    sw = 1'b0; hw = '0; ext = 1'b0; step(2);

    // R9 R12: starts while busy ignored; config changes mid-burst
    src = 0; clk_div = 2; trk_t = 2; res_sel = 1; rpt = 1; shf = 0; vin = 900;
    pulse_sw(); step(5);
    clk_div = 0; trk_t = 9; res_sel = 0; rpt = 3; shf = 2;
    for (int i = 0; i < 40; i++) begin sw = 1'b1; step(1); sw = 1'b0; step(1); end
    while (!done) step(1);
    // R9: start held through the done cycle is not taken
    sw = 1'b1; step(1); sw = 1'b0;
    chk("R12 latched", result, 1800);
    wait_idle();
    chk("R9 idle", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule